// File: doc/BRIEF.md
# Bit-Serial Significand Square Root

This unit extracts the square root of a normalized significand one result bit per clock. A fixed-point significand in [1, 2) and a flag telling whether the exponent is even are captured through a start/ready handshake. An even exponent doubles the operand, so the value whose root is taken, the radicand, lies in [2, 4). Each iteration forms a trial value from the partial root and compares it with the partial remainder. If the remainder covers the trial value, the next root bit is 1 and the trial value is subtracted. The remainder is then doubled, so the register always holds the remainder scaled by 2^n.

Because of this scaling, the register needs only four integer bits for the whole computation, even though the true remainder shrinks toward zero. After ROOT_W+1 iterations (the root width plus a guard bit), the unit registers the truncated root and a sticky flag. The sticky flag is set when the remainder is not zero. The unit pulses done for one cycle and then shows ready again. Exponent handling, rounding and special operands belong to the surrounding floating-point pipeline.

Top module: `sqrt_recur`

## Requirements
- R1: While reset is asserted and right after it, ready_o is 1, done_o is 0, root_o is 0 and sticky_o is 0.
- R2: An operation is accepted at a rising clock edge where start_i and ready_o are both 1, and ready_o is 0 in the following cycle. A start_i pulse while ready_o is 0 has no effect on the result or on the timing of the operation in progress.
- R3: With exp_even_i = 0, the radicand is x = sig_i / 2^FRAC_W. Bit FRAC_W of sig_i is the integer bit and is 1, so x lies in [1, 2).
- R4: With exp_even_i = 1, the radicand is 2·sig_i / 2^FRAC_W, which lies in [2, 4).
- R5: done_o is 1 for exactly one cycle. That cycle begins at the (ROOT_W+1)-th rising edge after the accepting edge. ready_o returns to 1 in the cycle after done_o.
- R6: root_o has ROOT_W+1 bits. Bit ROOT_W has weight 1 and the LSB has weight 2^-ROOT_W. The value r of root_o is the truncated root: r² <= radicand < (r + 2^-ROOT_W)².
- R7: sticky_o is 1 exactly when the radicand differs from r², that is, when the final remainder is not zero.
- R8: root_o and sticky_o keep their values from one done pulse until they are updated at the next one.
- R9: The scaled partial remainder never exceeds its four integer bits, up to the largest even-exponent radicand just below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| sig_i | input | FRAC_W+1 | Significand, integer bit at the MSB |
| exp_even_i | input | 1 | 1 when the exponent is even; the radicand is doubled |
| ready_o | output | 1 | Unit idle, start accepted |
| done_o | output | 1 | One-cycle completion pulse |
| root_o | output | ROOT_W+1 | Truncated root, one integer bit |
| sticky_o | output | 1 | Final remainder nonzero |

## Verification
The hardest situations to reach are those where the trial comparison lands exactly on equality. This happens when the radicand is a perfect square at the root's precision and the remainder falls to zero. It also happens at the top of the even range, where the scaled remainder comes closest to its width. Random significands almost never hit these cases, so the stimulus adds hand-picked operands. These are exact squares in both parity modes (25/16 and 2.25), the smallest operand 1 and the all-ones significand with both exponent parities. They are mixed with random operands and start pulses issued in the middle of a computation.

// File: rtl/sqrt_recur_pkg.sv
package sqrt_recur_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sqrt_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sqrt_recur_ctrl.sv
module sqrt_recur_ctrl
  import sqrt_recur_pkg::*;
#(
  parameter int STEPS = 25,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          ready_o,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic          done_o,
  output logic [CW-1:0] idx_o
);

  sqrt_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign ready_o = (state_q == ST_IDLE);
  assign load_o  = ready_o && start_i;
  assign step_o  = (state_q == ST_RUN);
  assign last_o  = step_o && (cnt_q == CW'(STEPS - 1));
  assign done_o  = (state_q == ST_DONE);
  assign idx_o   = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: if (last_o) state_d = ST_DONE;
              else        cnt_d   = cnt_q + 1'b1;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R5: completion is a single-cycle pulse followed by ready
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && ready_o));

  // R5: the step counter never runs past the iteration count
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (int'(cnt_q) < STEPS));

  // R2: an accepted start takes the unit out of ready
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

endmodule

// File: rtl/sqrt_recur_stage.sv
module sqrt_recur_stage #(
  parameter int IW    = 4,
  parameter int FW    = 24,
  parameter int STEPS = 25,
  parameter int CW    = 5,
  localparam int WR   = IW + FW,
  localparam int SH   = FW - STEPS + 2
) (
  input  logic [WR-1:0]    rem_i,
  input  logic [STEPS-1:0] root_i,
  input  logic [CW-1:0]    idx_i,
  output logic [WR-1:0]    rem_o,
  output logic [STEPS-1:0] root_o,
  output logic             bit_o,
  output logic             ovf_o
);

  logic [WR:0]   twice_root;
  logic [WR:0]   unit_bit;
  logic [WR:0]   trial;
  logic [WR:0]   diff;
  logic [WR-1:0] kept;

  always_comb begin
    twice_root = {{(WR + 1 - STEPS){1'b0}}, root_i} << SH;
    unit_bit   = {{WR{1'b0}}, 1'b1} << (FW - int'(idx_i));
    trial      = twice_root + unit_bit;
    diff       = {1'b0, rem_i} - trial;
    bit_o      = ~diff[WR];
    kept       = bit_o ? diff[WR-1:0] : rem_i;
    ovf_o      = kept[WR-1];
    rem_o      = {kept[WR-2:0], 1'b0};
    root_o     = root_i | ({{(STEPS - 1){1'b0}}, bit_o} << (STEPS - 1 - int'(idx_i)));
  end

endmodule

// File: rtl/sqrt_recur.sv
module sqrt_recur
  import sqrt_recur_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int ROOT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FRAC_W:0]   sig_i,
  input  logic              exp_even_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [ROOT_W:0]   root_o,
  output logic              sticky_o
);

  localparam int STEPS = ROOT_W + 1;
  localparam int IW    = 4;
  localparam int FW    = max_of(FRAC_W, STEPS - 1);
  localparam int WR    = IW + FW;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int SHIN  = FW - FRAC_W;

  logic          load, step, last;
  logic [CW-1:0] idx;
  logic [WR-1:0] rem_q, rem_d, rem_nx;
  logic [STEPS-1:0] part_q, part_d, part_nx;
  logic [STEPS-1:0] res_q, res_d;
  logic          sticky_q, sticky_d;
  logic          nx_bit, ovf;
  logic [FRAC_W+1:0] radicand;

  sqrt_recur_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_o (ready_o),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o),
    .idx_o   (idx)
  );

  sqrt_recur_stage #(.IW(IW), .FW(FW), .STEPS(STEPS), .CW(CW)) u_stage (
    .rem_i  (rem_q),
    .root_i (part_q),
    .idx_i  (idx),
    .rem_o  (rem_nx),
    .root_o (part_nx),
    .bit_o  (nx_bit),
    .ovf_o  (ovf)
  );

  assign radicand = exp_even_i ? {sig_i, 1'b0} : {1'b0, sig_i};

  always_comb begin
    rem_d    = rem_q;
    part_d   = part_q;
    res_d    = res_q;
    sticky_d = sticky_q;
    if (load) begin
      rem_d  = WR'(radicand) << SHIN;
      part_d = '0;
    end else if (step) begin
      rem_d  = rem_nx;
      part_d = part_nx;
      if (last) begin
        res_d    = part_nx;
        sticky_d = |rem_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      part_q   <= '0;
      res_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (load || step) begin
        rem_q  <= rem_d;
        part_q <= part_d;
      end
      if (last) begin
        res_q    <= res_d;
        sticky_q <= sticky_d;
      end
    end
  end

  assign root_o   = res_q;
  assign sticky_o = sticky_q;

  // R9: the scaled remainder keeps within its integer bits on every step
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !ovf);

  // R8: results move only at the end of an operation
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> ($stable(root_o) && $stable(sticky_o)));

endmodule

// File: tb/sqrt_recur_bench.sv
module sqrt_recur_bench;

  localparam int F  = 23;
  localparam int RW = 24;
  localparam int RB = RW + 1;
  localparam int MSH = 2 * (RB - 1) - F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [F:0]    sig_i = '0;
  logic          exp_even_i = 1'b0;
  logic          ready_o, done_o, sticky_o;
  logic [RW:0]   root_o;

  always #5 clk = ~clk;

  sqrt_recur #(.FRAC_W(F), .ROOT_W(RW)) u_sqrt_recur (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sig_i(sig_i),
    .exp_even_i(exp_even_i), .ready_o(ready_o), .done_o(done_o),
    .root_o(root_o), .sticky_o(sticky_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] isqrt(input logic [127:0] m);
    logic [127:0] q = '0;
    for (int i = 63; i >= 0; i--) begin
      logic [127:0] c;
      c = q | (128'(1) << i);
      if (c * c <= m) q = c;
    end
    return q;
  endfunction

  // behavioural model: 0 idle, 1 running, 2 done
  int            m_state = 0;
  int            m_cnt   = 0;
  logic [127:0]  q_rad[$];
  string         q_tag[$];
  logic [RW:0]   m_root = '0;
  bit            m_sticky = 1'b0;
  string         cur_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      m_cnt   = 0;
    end else begin
      case (m_state)
        0: if (start_i) begin
          q_rad.push_back(exp_even_i ? (128'(sig_i) << 1) : 128'(sig_i));
          q_tag.push_back(cur_tag);
          m_state = 1;
          m_cnt   = 0;
        end
        1: if (m_cnt == RB - 1) m_state = 2; else m_cnt++;
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready_o == (m_state == 0), "R2", "ready_o", 128'(ready_o), 128'(m_state == 0));
      chk(done_o == (m_state == 2), "R5", "done_o", 128'(done_o), 128'(m_state == 2));
      if (m_state == 2 && q_rad.size() > 0) begin
        logic [127:0] r, m, eq, q;
        string tg;
        r  = q_rad.pop_front();
        tg = q_tag.pop_front();
        m  = r << MSH;
        eq = isqrt(m);
        q  = 128'(root_o);
        chk(q == eq, tg, "root_o", q, eq);
        chk((q * q <= m) && (m < (q + 1) * (q + 1)), "R6", "root bracket", q, eq);
        chk(sticky_o == (eq * eq != m), "R7", "sticky_o", 128'(sticky_o), 128'(eq * eq != m));
        m_root   = RB'(eq);
        m_sticky = (eq * eq != m);
      end else begin
        chk(root_o == m_root, "R8", "root_o held", 128'(root_o), 128'(m_root));
        chk(sticky_o == m_sticky, "R8", "sticky_o held", 128'(sticky_o), 128'(m_sticky));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [F:0] s, input bit ev, input string tg, input bit poke);
    while (!ready_o) @(negedge clk);
    cur_tag    = tg;
    start_i    = 1'b1;
    sig_i      = s;
    exp_even_i = ev;
    @(negedge clk);
    start_i    = 1'b0;
    sig_i      = {1'b1, F'($urandom)};
    exp_even_i = ~ev;
    if (poke) begin
      // R2: start pulses while busy must be ignored
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R1", "ready_o in reset", 128'(ready_o), 128'(1));
    chk(done_o == 1'b0, "R1", "done_o in reset", 128'(done_o), 128'(0));
    chk(root_o == '0, "R1", "root_o in reset", 128'(root_o), 128'(0));
    chk(sticky_o == 1'b0, "R1", "sticky_o in reset", 128'(sticky_o), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run_op({1'b1, {F{1'b0}}}, 1'b0, "R3", 1'b0);          // x = 1
    run_op({(F+1){1'b1}}, 1'b0, "R3", 1'b0);               // largest x below 2
    run_op((F+1)'(25) << (F - 4), 1'b0, "R3", 1'b0);       // 25/16, exact root
    run_op({1'b1, {F{1'b0}}}, 1'b1, "R4", 1'b0);           // radicand 2
    run_op((F+1)'(9) << (F - 3), 1'b1, "R4", 1'b0);        // 2.25, exact root
    run_op({(F+1){1'b1}}, 1'b1, "R9", 1'b0);               // just below 4
    run_op({1'b1, F'($urandom)}, 1'b0, "R2", 1'b1);
    run_op({1'b1, F'($urandom)}, 1'b1, "R2", 1'b1);
    for (int i = 0; i < 300; i++) begin
      bit ev;
      ev = 1'($urandom);
      run_op({1'b1, F'($urandom)}, ev, ev ? "R4" : "R3", (i % 17) == 0);
    end
    while (!ready_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q_rad.size() == 0, "R5", "pending operations", 128'(q_rad.size()), 128'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule